// File: doc/BRIEF.md
# Masked Pixel Color Lookup Pipeline

This block is the pixel-clock half of a color palette. On every rising edge of the pixel clock it captures an 8-bit pixel index and a blanking flag. The captured index is ANDed bit by bit with a processor-owned mask, and the result addresses a 256-entry palette of 18-bit colors. Each entry is split into 6-bit red, green and blue outputs. The blanking flag travels through the same number of stages as the color data. While the delayed flag is set, all three color outputs read zero.

The mask and the palette entries are written from a processor clock that has no phase relation to the pixel clock. Palette writes go straight into the write port of a dual-clock memory. A mask write first lands in a processor-side shadow register, which the processor can read back at once. The value then crosses to the pixel domain as one word through a toggle request and acknowledge, each passed through a flop synchronizer. Changing the mask changes which entries are shown, but it leaves the palette contents as they were.

Top module: `mclut_top`

## Requirements
- R1: While either reset is low and right after it is released, the color outputs read zero, the delayed blanking output reads 1 and the mask read-back reads FFh. Until the first mask write, lookups behave as if the mask were FFh.
- R2: A pixel index captured at pixel-clock edge k has its color on the outputs after edge k+1 (two pixel-clock stages), and no earlier.
- R3: The blanking output equals the blanking input captured two pixel-clock edges earlier. Whenever the blanking output is 1, red, green and blue are all zero.
- R4: When blanking is 0, the palette location that is read equals the captured index ANDed bit by bit with the mask currently in effect in the pixel domain.
- R5: A processor palette write with palette-write-enable high stores the 18-bit word at the given address on the processor clock edge. Bits 17:12 appear on the red output, bits 11:6 on green and bits 5:0 on blue.
- R6: After a processor mask write, the mask read-back returns the written value on the next processor clock edge.
- R7: Every color output is looked up with either the complete old mask or the complete new mask, never with a mix of bits from the two.
- R8: A written mask takes effect in the pixel domain within a bounded number of cycles. When several mask writes arrive back to back, the mask that finally takes effect is the last one written.
- R9: Mask changes do not alter palette contents. Restoring the mask to FFh gives back the original color for every index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Pixel clock |
| prst_n | input | 1 | Active-low asynchronous reset, pixel domain |
| pix_idx_i | input | 8 | Pixel index, captured on the rising pixel-clock edge |
| pix_blank_i | input | 1 | Blanking flag, captured with the index |
| pix_red_o | output | 6 | Red value of the looked-up entry (palette bits 17:12) |
| pix_grn_o | output | 6 | Green value (palette bits 11:6) |
| pix_blu_o | output | 6 | Blue value (palette bits 5:0) |
| pix_blank_o | output | 1 | Blanking flag delayed to line up with the colors |
| cclk | input | 1 | Processor clock, asynchronous to pclk |
| crst_n | input | 1 | Active-low asynchronous reset, processor domain |
| cpu_mask_we_i | input | 1 | Mask write strobe |
| cpu_mask_wdata_i | input | 8 | Mask write value |
| cpu_mask_rdata_o | output | 8 | Mask read-back (latest written value) |
| cpu_pal_we_i | input | 1 | Palette write strobe |
| cpu_pal_addr_i | input | 8 | Palette write address |
| cpu_pal_wdata_i | input | 18 | Palette write data {red, green, blue} |

## Verification
The hardest case to reach from the ports is a mask update that lands in the middle of active pixels, since the exact pixel edge where it lands depends on how the two unrelated clocks line up. The stimulus keeps a non-blanked stream of changing indices running while it issues mask writes from the processor clock. For a short window after each write, the reference model accepts either the complete old-mask or the complete new-mask lookup and nothing else. A burst of back-to-back mask writes forces requests to be relaunched while a transfer is still in flight, so that the test can show the last value wins.

// File: rtl/mclut_pkg.sv
package mclut_pkg;
   // default geometry of the lookup
   localparam int unsigned DEF_IDX_W  = 8;
   localparam int unsigned DEF_CH_W   = 6;
   localparam int unsigned DEF_SYNC   = 2;
   localparam int unsigned NUM_CH     = 3;

   // channel slots inside one palette word, lowest slice first
   typedef enum logic [1:0] {
      CH_BLUE  = 2'd0,
      CH_GREEN = 2'd1,
      CH_RED   = 2'd2
   } chan_e;
endpackage

// File: rtl/mclut_sync_chain.sv
module mclut_sync_chain #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mclut_sync_chain: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] flops_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flops_q <= '0;
      else        flops_q <= {flops_q[STAGES-2:0], d_i};
   end

   assign q_o = flops_q[STAGES-1];
endmodule

// File: rtl/mclut_mask_xfer.sv
module mclut_mask_xfer #(
   parameter int unsigned   W           = 8,
   parameter int unsigned   SYNC_STAGES = 2,
   parameter logic [W-1:0]  RST_VAL     = '1
) (
   input  logic         cclk,
   input  logic         crst_n,
   input  logic         we_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] rdata_o,
   input  logic         pclk,
   input  logic         prst_n,
   output logic [W-1:0] mask_o
);
   generate
      if (W == 0) begin : g_bad_w
         $error("mclut_mask_xfer: W must be non-zero");
      end
   endgenerate

   // processor side
   logic [W-1:0] shadow_q;
   logic [W-1:0] hold_q;
   logic         pend_q;
   logic         req_q;
   logic         ack_s;
   logic         idle;
   logic         launch;

   // pixel side
   logic         req_s;
   logic         ack_q;
   logic         load;
   logic [W-1:0] mask_q;

   assign idle   = (req_q == ack_s);
   assign launch = pend_q && idle;

   always_ff @(posedge cclk or negedge crst_n) begin
      if (!crst_n) begin
         shadow_q <= RST_VAL;
         hold_q   <= RST_VAL;
         pend_q   <= 1'b0;
         req_q    <= 1'b0;
      end else begin
         if (we_i) shadow_q <= wdata_i;
         if (launch) begin
            hold_q <= shadow_q;
            req_q  <= ~req_q;
         end
         // a write in the same cycle as a launch keeps the slot pending
         if (we_i)        pend_q <= 1'b1;
         else if (launch) pend_q <= 1'b0;
      end
   end

   assign rdata_o = shadow_q;

   mclut_sync_chain #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk   (pclk),
      .rst_n (prst_n),
      .d_i   (req_q),
      .q_o   (req_s)
   );

   assign load = (req_s != ack_q);

   always_ff @(posedge pclk or negedge prst_n) begin
      if (!prst_n) begin
         ack_q  <= 1'b0;
         mask_q <= RST_VAL;
      end else begin
         ack_q <= req_s;
         if (load) mask_q <= hold_q;
      end
   end

   assign mask_o = mask_q;

   mclut_sync_chain #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk   (cclk),
      .rst_n (crst_n),
      .d_i   (ack_q),
      .q_o   (ack_s)
   );

   // R6
   rdback_chk: assert property (@(posedge cclk) disable iff (!crst_n)
      $past(we_i) |-> (rdata_o == $past(wdata_i)));

   // R7
   hold_stable_chk: assert property (@(posedge cclk) disable iff (!crst_n)
      (req_q != ack_s) |=> $stable(hold_q));

   // R7
   whole_word_chk: assert property (@(posedge pclk) disable iff (!prst_n)
      (mask_q != $past(mask_q)) |-> (mask_q == hold_q));
endmodule

// File: rtl/mclut_palette.sv
module mclut_palette #(
   parameter int unsigned AW = 8,
   parameter int unsigned DW = 18
) (
   input  logic          wclk,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          rclk,
   input  logic          rrst_n,
   input  logic [AW-1:0] raddr_i,
   output logic [DW-1:0] rdata_o
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];
   logic [DW-1:0] rd_q;

   always_ff @(posedge wclk) begin
      if (we_i) mem[waddr_i] <= wdata_i;
   end

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) rd_q <= '0;
      else         rd_q <= mem[raddr_i];
   end

   assign rdata_o = rd_q;
endmodule

// File: rtl/mclut_pix_pipe.sv
module mclut_pix_pipe
   import mclut_pkg::*;
#(
   parameter int unsigned IDX_W = 8,
   parameter int unsigned CH_W  = 6
) (
   input  logic                    pclk,
   input  logic                    prst_n,
   input  logic [IDX_W-1:0]        idx_i,
   input  logic                    blank_i,
   input  logic [IDX_W-1:0]        mask_i,
   output logic [IDX_W-1:0]        raddr_o,
   input  logic [NUM_CH*CH_W-1:0]  rdata_i,
   output logic [CH_W-1:0]         red_o,
   output logic [CH_W-1:0]         grn_o,
   output logic [CH_W-1:0]         blu_o,
   output logic                    blank_o
);
   logic [IDX_W-1:0] idx_q;
   logic             blank_s1_q;
   logic             blank_s2_q;
   logic [CH_W-1:0]  chan [NUM_CH];
   logic [1:0]       since_q;

   always_ff @(posedge pclk or negedge prst_n) begin
      if (!prst_n) begin
         idx_q      <= '0;
         blank_s1_q <= 1'b1;
         blank_s2_q <= 1'b1;
      end else begin
         idx_q      <= idx_i;
         blank_s1_q <= blank_i;
         blank_s2_q <= blank_s1_q;
      end
   end

   // masked address feeds the registered read port of the palette
   assign raddr_o = idx_q & mask_i;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
         assign chan[c] = blank_s2_q ? '0 : rdata_i[c*CH_W +: CH_W];
      end
   endgenerate

   assign red_o   = chan[CH_RED];
   assign grn_o   = chan[CH_GREEN];
   assign blu_o   = chan[CH_BLUE];
   assign blank_o = blank_s2_q;

   always_ff @(posedge pclk or negedge prst_n) begin
      if (!prst_n)           since_q <= '0;
      else if (since_q != 2'd2) since_q <= since_q + 2'd1;
   end

   // R3
   blank_delay_chk: assert property (@(posedge pclk) disable iff (!prst_n)
      (since_q == 2'd2) |-> (blank_o == $past(blank_i, 2)));

   // R3
   blank_zero_chk: assert property (@(posedge pclk) disable iff (!prst_n)
      blank_o |-> (red_o == '0 && grn_o == '0 && blu_o == '0));
endmodule

// File: rtl/mclut_top.sv
module mclut_top
   import mclut_pkg::*;
#(
   parameter int unsigned IDX_W       = DEF_IDX_W,
   parameter int unsigned CH_W        = DEF_CH_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
   input  logic                    pclk,
   input  logic                    prst_n,
   input  logic [IDX_W-1:0]        pix_idx_i,
   input  logic                    pix_blank_i,
   output logic [CH_W-1:0]         pix_red_o,
   output logic [CH_W-1:0]         pix_grn_o,
   output logic [CH_W-1:0]         pix_blu_o,
   output logic                    pix_blank_o,
   input  logic                    cclk,
   input  logic                    crst_n,
   input  logic                    cpu_mask_we_i,
   input  logic [IDX_W-1:0]        cpu_mask_wdata_i,
   output logic [IDX_W-1:0]        cpu_mask_rdata_o,
   input  logic                    cpu_pal_we_i,
   input  logic [IDX_W-1:0]        cpu_pal_addr_i,
   input  logic [NUM_CH*CH_W-1:0]  cpu_pal_wdata_i
);
   localparam int unsigned ENTRY_W = NUM_CH * CH_W;

   generate
      if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
         $error("mclut_top: IDX_W must be within 1..12");
      end
      if (CH_W < 1) begin : g_bad_ch
         $error("mclut_top: CH_W must be non-zero");
      end
   endgenerate

   logic [IDX_W-1:0]   mask_pix;
   logic [IDX_W-1:0]   raddr;
   logic [ENTRY_W-1:0] rdata;

   mclut_mask_xfer #(
      .W           (IDX_W),
      .SYNC_STAGES (SYNC_STAGES),
      .RST_VAL     ({IDX_W{1'b1}})
   ) u_mask (
      .cclk    (cclk),
      .crst_n  (crst_n),
      .we_i    (cpu_mask_we_i),
      .wdata_i (cpu_mask_wdata_i),
      .rdata_o (cpu_mask_rdata_o),
      .pclk    (pclk),
      .prst_n  (prst_n),
      .mask_o  (mask_pix)
   );

   mclut_palette #(
      .AW (IDX_W),
      .DW (ENTRY_W)
   ) u_pal (
      .wclk    (cclk),
      .we_i    (cpu_pal_we_i),
      .waddr_i (cpu_pal_addr_i),
      .wdata_i (cpu_pal_wdata_i),
      .rclk    (pclk),
      .rrst_n  (prst_n),
      .raddr_i (raddr),
      .rdata_o (rdata)
   );

   mclut_pix_pipe #(
      .IDX_W (IDX_W),
      .CH_W  (CH_W)
   ) u_pipe (
      .pclk    (pclk),
      .prst_n  (prst_n),
      .idx_i   (pix_idx_i),
      .blank_i (pix_blank_i),
      .mask_i  (mask_pix),
      .raddr_o (raddr),
      .rdata_i (rdata),
      .red_o   (pix_red_o),
      .grn_o   (pix_grn_o),
      .blu_o   (pix_blu_o),
      .blank_o (pix_blank_o)
   );

   // R1
   rst_mask_chk: assert property (@(posedge cclk)
      (!crst_n) |=> (cpu_mask_rdata_o == {IDX_W{1'b1}}));
endmodule

// File: tb/mclut_top_tb_top.sv
`timescale 1ns/1ps
module mclut_top_tb_top;
   localparam int PCLK_HALF = 10;   // 50 MHz pixel clock
   localparam int CCLK_HALF = 13;   // unrelated processor clock
   localparam int WIN_NS    = 24 * 2 * PCLK_HALF;

   logic        pclk = 1'b0;
   logic        cclk = 1'b0;
   logic        prst_n = 1'b0;
   logic        crst_n = 1'b0;
   logic [7:0]  pix_idx = 8'h00;
   logic        pix_blank = 1'b1;
   logic [5:0]  red, grn, blu;
   logic        blank_o;
   logic        m_we = 1'b0;
   logic [7:0]  m_wdata = 8'h00;
   logic [7:0]  m_rdata;
   logic        p_we = 1'b0;
   logic [7:0]  p_addr = 8'h00;
   logic [17:0] p_wdata = '0;

   always #(PCLK_HALF) pclk = ~pclk;
   always #(CCLK_HALF) cclk = ~cclk;

   mclut_top dut_i (
      .pclk             (pclk),
      .prst_n           (prst_n),
      .pix_idx_i        (pix_idx),
      .pix_blank_i      (pix_blank),
      .pix_red_o        (red),
      .pix_grn_o        (grn),
      .pix_blu_o        (blu),
      .pix_blank_o      (blank_o),
      .cclk             (cclk),
      .crst_n           (crst_n),
      .cpu_mask_we_i    (m_we),
      .cpu_mask_wdata_i (m_wdata),
      .cpu_mask_rdata_o (m_rdata),
      .cpu_pal_we_i     (p_we),
      .cpu_pal_addr_i   (p_addr),
      .cpu_pal_wdata_i  (p_wdata)
   );

   // reference state
   logic [17:0] pal_m [256];
   logic [7:0]  mask_cur = 8'hFF;
   logic [7:0]  mask_old = 8'hFF;
   time         mask_t   = 0;
   logic [8:0]  hq [$];       // {blank, idx} captured per pixel edge
   bit          run_cmp = 1'b0;
   int          cmp_auto = 0, bad_auto = 0;
   int          cmp_dir  = 0, bad_dir  = 0;

   function automatic logic [17:0] pal_fn(input int i);
      return 18'((i * 32'h10B3 + 32'h25A1) & 32'h3FFFF);
   endfunction

   always @(posedge pclk or negedge prst_n) begin
      if (!prst_n) begin
         hq.delete();
         hq.push_back({1'b1, 8'h00});
      end else begin
         hq.push_back({pix_blank, pix_idx});
         if (hq.size() > 4) void'(hq.pop_front());
      end
   end

   // per-clock comparison against the model
   always @(negedge pclk) begin
      if (run_cmp) begin
         logic [8:0]  e;
         logic [17:0] a, b_old, b_new;
         logic        ok;
         string       tag;
         e = (hq.size() < 2) ? {1'b1, 8'h00} : hq[hq.size()-2];
         a = {red, grn, blu};
         if (e[8]) begin
            b_new = '0; b_old = '0; tag = "R3";
         end else begin
            b_new = pal_m[e[7:0] & mask_cur];
            b_old = pal_m[e[7:0] & mask_old];
            tag = "R4";
         end
         ok = (blank_o === e[8]) && (a === b_new);
         if (!ok && !e[8] && ($time - mask_t) < WIN_NS) begin
            tag = "R7";
            ok = (blank_o === e[8]) && (a === b_old);
         end
         cmp_auto++;
         if (!ok) begin
            bad_auto++;
            $display("FAIL %s t=%0t actual blank=%b rgb=%h expected blank=%b rgb=%h",
                     tag, $time, blank_o, a, e[8], b_new);
         end
      end
   end

   task automatic chk(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
      cmp_dir++;
      if (!cond) begin
         bad_dir++;
         $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   task automatic pal_write(input logic [7:0] a, input logic [17:0] d);
      @(negedge cclk); p_we = 1'b1; p_addr = a; p_wdata = d;
      @(negedge cclk); p_we = 1'b0;
      pal_m[a] = d;
   endtask

   task automatic mask_write(input logic [7:0] m);
      @(negedge cclk); m_we = 1'b1; m_wdata = m;
      @(negedge cclk); m_we = 1'b0;
      // R6: read-back follows one processor edge after the write
      chk(m_rdata === m, "R6", {24'h0, m_rdata}, {24'h0, m});
      mask_old = mask_cur;
      mask_cur = m;
      mask_t   = $time;
   endtask

   task automatic pix(input logic [7:0] i, input logic b);
      @(negedge pclk); pix_idx = i; pix_blank = b;
   endtask

   task automatic idle_pix(input int n);
      for (int k = 0; k < n; k++) pix(8'h00, 1'b1);
   endtask

   task automatic stream(input int n, input int seed);
      int s;
      s = seed;
      for (int k = 0; k < n; k++) begin
         s = (s * 1103515245 + 12345) & 32'h7FFFFFFF;
         pix(8'(s >> 8), (k % 7) == 6);
      end
   endtask

   initial begin
      #(2000 * 2 * PCLK_HALF * 100);
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***",
               cmp_auto + cmp_dir + 1, bad_auto + bad_dir + 1);
      $finish;
   end

   initial begin
      for (int k = 0; k < 256; k++) pal_m[k] = '0;
      #(5 * 2 * PCLK_HALF);
      // R1: reset state of the outputs and of the mask read-back
      @(negedge pclk);
      chk(blank_o === 1'b1, "R1", {31'h0, blank_o}, 32'h1);
      chk({red, grn, blu} === 18'h0, "R1", {14'h0, red, grn, blu}, 32'h0);
      chk(m_rdata === 8'hFF, "R1", {24'h0, m_rdata}, 32'hFF);
      @(negedge pclk); prst_n = 1'b1; crst_n = 1'b1;
      run_cmp = 1'b1;
      for (int k = 0; k < 256; k++) pal_write(8'(k), pal_fn(k));
      idle_pix(4);

      // R1: unmasked lookups after reset
      pix(8'hA7, 1'b0); pix(8'h00, 1'b1);
      @(negedge pclk);
      chk({red, grn, blu} === pal_fn(8'hA7), "R1", {14'h0, red, grn, blu}, {14'h0, pal_fn(8'hA7)});

      // R2: one isolated pixel, not visible early, visible after two edges
      idle_pix(3);
      pix(8'h5B, 1'b0); pix(8'h00, 1'b1);
      chk(blank_o === 1'b1, "R2", {31'h0, blank_o}, 32'h1);
      @(negedge pclk);
      chk(blank_o === 1'b0 && {red, grn, blu} === pal_fn(8'h5B), "R2",
          {14'h0, red, grn, blu}, {14'h0, pal_fn(8'h5B)});
      idle_pix(3);

      // R5: field positions of a palette word
      pal_write(8'h3C, {6'h2A, 6'h15, 6'h3F});
      pix(8'h3C, 1'b0); pix(8'h00, 1'b1);
      @(negedge pclk);
      chk(red === 6'h2A, "R5", {26'h0, red}, 32'h2A);
      chk(grn === 6'h15, "R5", {26'h0, grn}, 32'h15);
      chk(blu === 6'h3F, "R5", {26'h0, blu}, 32'h3F);
      idle_pix(3);

      // R3/R4: sequential, random and blank-interleaved streams
      for (int k = 0; k < 256; k++) pix(8'(k), 1'b0);
      stream(600, 7);

      // R4/R7: mask changes while active pixels keep flowing
      fork
         stream(900, 99);
         begin
            mask_write(8'h0F);
            #(200 * 2 * PCLK_HALF);
            mask_write(8'hC3);
            #(200 * 2 * PCLK_HALF);
            mask_write(8'h00);
         end
      join
      idle_pix(4);

      // R4: mask 00h shows entry 0 for every index
      pix(8'hEE, 1'b0); pix(8'h00, 1'b1);
      @(negedge pclk);
      chk({red, grn, blu} === pal_fn(0), "R4", {14'h0, red, grn, blu}, {14'h0, pal_fn(0)});

      // R8: burst of mask writes, last one wins
      mask_write(8'h33);
      mask_write(8'h5A);
      mask_write(8'hF0);
      idle_pix(100);
      pix(8'hFF, 1'b0); pix(8'h00, 1'b1);
      @(negedge pclk);
      chk({red, grn, blu} === pal_fn(8'hF0), "R8", {14'h0, red, grn, blu}, {14'h0, pal_fn(8'hF0)});
      idle_pix(2);

      // R9: restore the mask, palette content unchanged
      mask_write(8'hFF);
      idle_pix(40);
      for (int k = 0; k < 256; k++) begin
         pix(8'(k), 1'b0); pix(8'h00, 1'b1);
         @(negedge pclk);
         chk({red, grn, blu} === pal_m[k], "R9", {14'h0, red, grn, blu}, {14'h0, pal_m[k]});
      end
      stream(300, 1234);
      idle_pix(4);

      run_cmp = 1'b0;
      @(negedge pclk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***",
               cmp_auto + cmp_dir, bad_auto + bad_dir);
      $finish;
   end
endmodule